// File: doc/BRIEF.md
# Master Clock Rate Detector

This block works out which of three master-clock rates is feeding it. It needs no strap or selection pin. It counts master-clock cycles between successive rising edges of the 8 kHz frame reference, whose period is 125 µs. At the 2.048 MHz, 4.096 MHz and 8.192 MHz rates that span is nominally 256, 512 or 1024 cycles. The frame reference comes from the PCM side, which runs asynchronously to the master clock, so the block first brings it into the master-clock domain through a flop synchronizer. It then extracts the rising edge.

Each measured span is compared against three inclusive windows of ±`TOL_CNT` cycles. A rate code is reported, with a locked flag, only once the same code has been seen for `LOCK_FRAMES` measurements in a row. A span that fits no window drops lock and raises an error flag. Downstream timing dividers use the code and the locked flag to build internal clocks.

Top module: `mclk_rate_detect`

## Requirements
- R1: After reset, and whenever rst_ni is low, rate_o is 2'b11, locked_o is 0 and err_o is 0.
- R2: A measurement is the number of clk_i cycles between two consecutive rising edges of the synchronized frame reference. The first rising edge after reset yields no measurement.
- R3: A measurement within BASE_CNT·2^k ± TOL_CNT maps to code k. Code 2'b00 means 1×BASE_CNT (2.048 MHz at default), 2'b01 means 2× (4.096 MHz) and 2'b10 means 4× (8.192 MHz).
- R4: The windows include their bounds. A count of BASE_CNT·2^k ± (TOL_CNT+1), or a count between windows, is invalid.
- R5: locked_o rises after LOCK_FRAMES consecutive measurements that carry the same valid code. rate_o shows that code while locked_o is 1 and 2'b11 otherwise.
- R6: An invalid measurement clears locked_o, sets err_o and restarts the run count.
- R7: err_o stays set until a fresh run of LOCK_FRAMES identical valid codes sets locked_o. At that point err_o clears.
- R8: A valid code that differs from the previous one clears locked_o without setting err_o. The new code then needs its own full run to lock.
- R9: fsync_i is asynchronous. Only its rising edges count, so a frame pulse of any width is taken once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock being measured |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | 8 kHz frame reference, asynchronous to clk_i |
| rate_o | output | 2 | Detected rate code, 2'b11 when not locked |
| locked_o | output | 1 | Rate code has been stable for the lock run |
| err_o | output | 1 | Last run was broken by an out-of-window count |

## Verification
The bench builds the block with BASE_CNT=32, TOL_CNT=2 and LOCK_FRAMES=3. Frames therefore last 32, 64 or 128 cycles instead of up to 1024. This puts every window edge (29, 30, 34, 35, 62, 66, 126, 130), gaps between windows and counts above the top window within a few thousand cycles. The short frames also leave time to repeat lock, loss of lock, relock and rate changes many times from a fresh reset.

// File: rtl/mclk_det_pkg.sv
package mclk_det_pkg;
  typedef enum logic [1:0] {
    RATE_X1   = 2'b00,
    RATE_X2   = 2'b01,
    RATE_X4   = 2'b10,
    RATE_NONE = 2'b11
  } rate_e;

  localparam int NUM_RATES = 3;
endpackage

// File: rtl/fsync_edge.sv
module fsync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q  <= CNT_W'(1);
      seen_q <= 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;  // saturates so a lost reference reads as invalid
    end
  end

  assign cnt_o   = cnt_q;
  assign valid_o = rise_i & seen_q;

  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (cnt_q == CNT_W'(1)));
  a_r2_first_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(seen_q || rise_i));
endmodule

// File: rtl/rate_classifier.sv
module rate_classifier
  import mclk_det_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int BASE_CNT = 256,
  parameter int TOL_CNT  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  output rate_e            code_o
);
  logic [NUM_RATES-1:0] hit;
  logic [31:0]          cnt_ext;

  assign cnt_ext = 32'(cnt_i);

  for (genvar k = 0; k < NUM_RATES; k++) begin : g_win
    localparam int unsigned LO = (BASE_CNT << k) - TOL_CNT;
    localparam int unsigned HI = (BASE_CNT << k) + TOL_CNT;
    assign hit[k] = (cnt_ext >= LO) && (cnt_ext <= HI);
  end

  always_comb begin
    code_o = RATE_NONE;
    for (int k = NUM_RATES - 1; k >= 0; k--) begin
      if (hit[k]) code_o = rate_e'(2'(k));
    end
  end

  a_r4_disjoint_windows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: rtl/lock_tracker.sv
module lock_tracker
  import mclk_det_pkg::*;
#(
  parameter int LOCK_FRAMES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  rate_e      code_i,
  output logic [1:0] rate_o,
  output logic       locked_o,
  output logic       err_o
);
  localparam int RUN_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_FRAMES);

  rate_e            last_q;
  logic [RUN_W-1:0] run_q, run_d;
  logic             locked_q, err_q;

  always_comb begin
    if (code_i == last_q && run_q != '0)
      run_d = (run_q == RUN_FULL) ? run_q : run_q + 1'b1;
    else
      run_d = RUN_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q   <= RATE_NONE;
      run_q    <= '0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (valid_i) begin
      if (code_i == RATE_NONE) begin
        last_q   <= RATE_NONE;
        run_q    <= '0;
        locked_q <= 1'b0;
        err_q    <= 1'b1;
      end else begin
        last_q   <= code_i;
        run_q    <= run_d;
        locked_q <= (run_d == RUN_FULL);
        if (run_d == RUN_FULL) err_q <= 1'b0;
      end
    end
  end

  assign rate_o   = locked_q ? last_q : RATE_NONE;
  assign locked_o = locked_q;
  assign err_o    = err_q;

  a_r6_err_not_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !locked_o);
  a_r6_invalid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && code_i == RATE_NONE) |=> (err_o && !locked_o));
  a_r5_lock_on_measure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(valid_i));
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !valid_i) |=> err_o);
  a_r5_quiet_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(locked_o) && $stable(rate_o)));
  a_r8_change_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && locked_o && code_i != RATE_NONE && code_i != rate_e'(rate_o))
      |=> (!locked_o && !err_o));
endmodule

// File: rtl/mclk_rate_detect.sv
module mclk_rate_detect
  import mclk_det_pkg::*;
#(
  parameter int BASE_CNT    = 256,
  parameter int TOL_CNT     = 4,
  parameter int LOCK_FRAMES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fsync_i,
  output logic [1:0] rate_o,
  output logic       locked_o,
  output logic       err_o
);
  localparam int CNT_W = $clog2(4 * BASE_CNT + 2 * TOL_CNT + 2);

  logic             rise;
  logic             meas_valid;
  logic [CNT_W-1:0] meas_cnt;
  rate_e            meas_code;

  fsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (fsync_i),
    .rise_o  (rise)
  );

  period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .cnt_o   (meas_cnt),
    .valid_o (meas_valid)
  );

  rate_classifier #(
    .CNT_W    (CNT_W),
    .BASE_CNT (BASE_CNT),
    .TOL_CNT  (TOL_CNT)
  ) u_cls (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (meas_cnt),
    .code_o (meas_code)
  );

  lock_tracker #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (meas_valid),
    .code_i   (meas_code),
    .rate_o   (rate_o),
    .locked_o (locked_o),
    .err_o    (err_o)
  );

  a_r5_locked_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (rate_o != 2'b11));
  a_r1_idle_after_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!locked_o && !err_o && rate_o == 2'b11));
endmodule

// File: tb/tb_mclk_rate_detect.sv
module tb_mclk_rate_detect;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 32;
  localparam int TOL  = 2;
  localparam int LOCK = 3;
  localparam int NV   = 13;

  // period, frames, expected rate, locked, err
  localparam int VP[NV] = '{32, 64, 128, 30, 34, 126, 66, 29, 35, 96, 64, 200, 32};
  localparam int VN[NV] = '{ 4,  4,   4,  4,  4,   4,  4,  4,  4,  4,  3,   2,  1};
  localparam int VR[NV] = '{ 0,  1,   2,  0,  0,   2,  1,  3,  3,  3,  3,   3,  3};
  localparam int VL[NV] = '{ 1,  1,   1,  1,  1,   1,  1,  0,  0,  0,  0,   0,  0};
  localparam int VE[NV] = '{ 0,  0,   0,  0,  0,   0,  0,  1,  1,  1,  0,   1,  0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fsync = 1'b0;
  logic [1:0] rate;
  logic locked, err;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mclk_rate_detect #(
    .BASE_CNT    (BASE),
    .TOL_CNT     (TOL),
    .LOCK_FRAMES (LOCK),
    .SYNC_STAGES (2)
  ) dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .fsync_i  (fsync),
    .rate_o   (rate),
    .locked_o (locked),
    .err_o    (err)
  );

  task automatic chk(input string req, input int er, input int el, input int ee);
    checks++;
    if (rate !== 2'(er) || locked !== 1'(el) || err !== 1'(ee)) begin
      fails++;
      $display("FAIL %s: got rate=%0d locked=%0d err=%0d expected rate=%0d locked=%0d err=%0d",
               req, rate, locked, err, er, el, ee);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    fsync  = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input int p, input int w);
    fsync = 1'b1;
    repeat (w) @(negedge clk);
    fsync = 1'b0;
    repeat (p - w) @(negedge clk);
  endtask

  task automatic frames(input int p, input int n);
    for (int i = 0; i < n; i++) frame(p, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: got hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 in reset", 3, 0, 0);
    do_reset();
    chk("R1 after reset", 3, 0, 0);

    // R2 R3 R4 R5 R6: table of single-period runs
    for (int v = 0; v < NV; v++) begin
      do_reset();
      frames(VP[v], VN[v]);
      chk($sformatf("R3/R4/R5 vector %0d period %0d", v, VP[v]), VR[v], VL[v], VE[v]);
    end

    // R6 then R7: lock, bad frame, relock
    do_reset();
    frames(32, 4);
    chk("R5 lock x1", 0, 1, 0);
    frame(50, 2);
    frame(32, 2);
    chk("R6 invalid drops lock", 3, 0, 1);
    frames(32, 2);
    chk("R7 err held during partial run", 3, 0, 1);
    frame(32, 2);
    chk("R7 err cleared on relock", 0, 1, 0);

    // R8: rate change without error
    do_reset();
    frames(32, 4);
    frames(64, 2);
    chk("R8 change unlocks", 3, 0, 0);
    frames(64, 2);
    chk("R8 relock new rate", 1, 1, 0);

    // R9: wide frame pulse counted once per frame
    do_reset();
    for (int i = 0; i < 4; i++) frame(64, 40);
    chk("R9 wide pulse", 1, 1, 0);

    // R1: reset while locked
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 reset while locked", 3, 0, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R2: mixed run, lock only after three equal codes
    do_reset();
    frames(32, 2);
    frames(128, 3);
    chk("R2 mixed run short", 3, 0, 0);
    frame(128, 2);
    chk("R2 mixed run locks", 2, 1, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule